// File: doc/BRIEF.md
# Multi-Mode Byte DMA Channel Engine

This block carries out a single general-purpose DMA transfer for one channel. It moves bytes between a 24-bit A-bus location and an 8-bit B-bus register port. The A-bus location is an 8-bit bank plus a 16-bit offset. Software or a sequencer first sets up the channel configuration: direction, transfer mode, A-offset step, B port, byte count, bank and starting offset. It then pulses `start`. The engine makes one byte move per step. Each move is a read from the source bus followed by a write to the destination bus. The live offset and remaining count are updated after every byte.

The transfer mode picks the order of B-port offsets that successive bytes visit. This lets a single transfer feed word-wide or paired register targets. The sequence continues across the whole transfer. The timing follows a fixed budget: a channel setup period, then a fixed slot per byte. Two conditions change the normal flow. A RAM-to-itself move through the RAM data port is suppressed but still spends its time. A collision with a per-line transfer on the same channel kills the transfer at once. Both bus ports use a plain request/acknowledge handshake.

Top module: `dma_byte_engine`

## Requirements
- R1: `start` is taken only while `busy` is low. A `start` pulse during a transfer changes neither the configuration in use nor the result.
- R2: With bus ports that acknowledge in the same cycle, a transfer of N bytes takes OVH_CYC + N·BYTE_CYC cycles (8 + 8N by default). The count runs from the accepting clock edge to the cycle in which `done` is high. `done` is a one-cycle pulse with `aborted` low, and `cur_count` is then 0.
- R3: A programmed count of 0 means 65536 bytes. After k bytes, `cur_count` reads 65536−k and `busy` stays high.
- R4: The step field `cfg_step` is decoded as 2'b00 = +1, 2'b01 = −1, 2'b1x = fixed. The step is applied to the offset after each byte. The offset wraps within 16 bits, and the bank is never altered.
- R5: Modes 0, 2 and 6 send every byte to port offset +0.
- R6: Modes 1 and 5 alternate +0, +1. A transfer with an odd count ends on a +0 access.
- R7: Modes 3 and 7 repeat the order +0, +0, +1, +1.
- R8: Mode 4 repeats the order +0, +1, +2, +3.
- R9: When `cfg_b_to_a`=1, each byte is read from the B port and written to the A address. The same mode offsets and offset steps apply.
- R10: A transfer in the A→B direction is blocked when the bank is 0x7E or 0x7F and the port is 0x80. A blocked transfer makes no bus access of either kind. The count still runs down, the offset still steps, and the timing of R2 still holds. The B→A direction with the same bank and port is performed normally.
- R11: When `line_hit` is high during a transfer, the engine goes idle on that edge. `done` and `aborted` then pulse together. `cur_addr` and `cur_count` keep the values of the last completed byte.
- R12: After reset the engine is idle: `busy`, `done`, `aborted`, `a_req` and `b_req` are low, and `cur_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| cfg_b_to_a | input | 1 | 1: B port to A address; 0: A address to B port |
| cfg_mode | input | 3 | Port offset sequence select |
| cfg_step | input | 2 | A-offset step: 00 +1, 01 −1, 1x fixed |
| cfg_port | input | 8 | B port base |
| cfg_count | input | 16 | Byte count, 0 means 65536 |
| cfg_bank | input | 8 | A bank |
| cfg_addr | input | 16 | Starting A offset |
| line_hit | input | 1 | Same-channel per-line transfer fired; aborts |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end pulse |
| aborted | output | 1 | High with `done` when ended by `line_hit` |
| cur_addr | output | 16 | Live A offset |
| cur_count | output | 16 | Live remaining count |
| a_req | output | 1 | A-bus access request |
| a_we | output | 1 | A-bus write when high |
| a_addr | output | 24 | A-bus address {bank, offset} |
| a_wdata | output | 8 | A-bus write data |
| a_rdata | input | 8 | A-bus read data |
| a_ack | input | 1 | A-bus access complete |
| b_req | output | 1 | B-bus access request |
| b_we | output | 1 | B-bus write when high |
| b_addr | output | 8 | B-bus port address |
| b_wdata | output | 8 | B-bus write data |
| b_rdata | input | 8 | B-bus read data |
| b_ack | input | 1 | B-bus access complete |

## Verification
The hardest state to reach is an abort in the middle of a slot. In that state a byte's bus accesses have already been made, but its count and offset update has not yet happened. The stimulus raises `line_hit` a counted number of cycles after start, inside the fourth byte slot. It then expects the registers to show only three completed bytes. The zero-count case cannot be run to its end within the cycle budget. It is therefore reached by letting a count-0 transfer run three bytes, reading `cur_count` as 0xFFFD, and ending it with the same abort.

// File: rtl/dma_byte_engine.sv
`timescale 1ns/1ps
module dma_byte_engine #(
  parameter int AW       = 16,
  parameter int BKW      = 8,
  parameter int DW       = 8,
  parameter int BW       = 8,
  parameter int OVH_CYC  = 8,
  parameter int BYTE_CYC = 8,
  parameter logic [BKW-1:0] RAM_BANK_LO = 8'h7E,
  parameter logic [BKW-1:0] RAM_BANK_HI = 8'h7F,
  parameter logic [BW-1:0]  RAM_PORT    = 8'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               cfg_b_to_a,
  input  logic [2:0]         cfg_mode,
  input  logic [1:0]         cfg_step,
  input  logic [BW-1:0]      cfg_port,
  input  logic [AW-1:0]      cfg_count,
  input  logic [BKW-1:0]     cfg_bank,
  input  logic [AW-1:0]      cfg_addr,
  input  logic               line_hit,
  output logic               busy,
  output logic               done,
  output logic               aborted,
  output logic [AW-1:0]      cur_addr,
  output logic [AW-1:0]      cur_count,
  output logic               a_req,
  output logic               a_we,
  output logic [BKW+AW-1:0]  a_addr,
  output logic [DW-1:0]      a_wdata,
  input  logic [DW-1:0]      a_rdata,
  input  logic               a_ack,
  output logic               b_req,
  output logic               b_we,
  output logic [BW-1:0]      b_addr,
  output logic [DW-1:0]      b_wdata,
  input  logic [DW-1:0]      b_rdata,
  input  logic               b_ack
);
  localparam int TMAX = (OVH_CYC > BYTE_CYC) ? OVH_CYC : BYTE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] OVH_LAST  = TW'(OVH_CYC - 1);
  localparam logic [TW-1:0] SLOT_LAST = TW'(BYTE_CYC - 1);
  localparam logic [TW-1:0] T_SAT     = TW'(TMAX);

  typedef enum logic [2:0] {S_IDLE, S_OVH, S_RD, S_WR, S_PAD} st_t;

  st_t            st;
  logic [TW-1:0]  tcnt;
  logic           rev_q, blk_q;
  logic [2:0]     mode_q;
  logic [1:0]     step_q, pos_q, off;
  logic [BW-1:0]  port_q;
  logic [BKW-1:0] bank_q;
  logic [AW-1:0]  addr_q, cnt_q, addr_nxt;
  logic [DW-1:0]  data_q;
  logic           done_q, abort_q;
  logic           step_ack, slot_end, blocked_cfg;

  always_comb begin
    case (mode_q)
      3'd1, 3'd5: off = {1'b0, pos_q[0]};
      3'd3, 3'd7: off = {1'b0, pos_q[1]};
      3'd4:       off = pos_q;
      default:    off = 2'd0;
    endcase
  end

  assign addr_nxt = step_q[1] ? addr_q : (step_q[0] ? addr_q - 1'b1 : addr_q + 1'b1);
  assign blocked_cfg = (cfg_bank == RAM_BANK_LO || cfg_bank == RAM_BANK_HI) &&
                       cfg_port == RAM_PORT && !cfg_b_to_a;

  assign busy      = st != S_IDLE;
  assign done      = done_q;
  assign aborted   = abort_q;
  assign cur_addr  = addr_q;
  assign cur_count = cnt_q;

  assign a_req   = (st == S_RD && !rev_q) || (st == S_WR && rev_q);
  assign a_we    = st == S_WR && rev_q;
  assign a_addr  = {bank_q, addr_q};
  assign a_wdata = data_q;
  assign b_req   = (st == S_RD && rev_q) || (st == S_WR && !rev_q);
  assign b_we    = st == S_WR && !rev_q;
  assign b_addr  = port_q + {{(BW-2){1'b0}}, off};
  assign b_wdata = data_q;

  assign step_ack = (st == S_RD) ? (rev_q ? b_ack : a_ack) : (rev_q ? a_ack : b_ack);
  assign slot_end = st == S_PAD && tcnt >= SLOT_LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tcnt    <= '0;
      rev_q   <= 1'b0;
      blk_q   <= 1'b0;
      mode_q  <= '0;
      step_q  <= '0;
      pos_q   <= '0;
      port_q  <= '0;
      bank_q  <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      if (st != S_IDLE && tcnt != T_SAT) tcnt <= tcnt + 1'b1;
      if (st != S_IDLE && line_hit) begin
        st      <= S_IDLE;
        done_q  <= 1'b1;
        abort_q <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            st     <= S_OVH;
            tcnt   <= '0;
            rev_q  <= cfg_b_to_a;
            blk_q  <= blocked_cfg;
            mode_q <= cfg_mode;
            step_q <= cfg_step;
            pos_q  <= '0;
            port_q <= cfg_port;
            bank_q <= cfg_bank;
            addr_q <= cfg_addr;
            cnt_q  <= cfg_count;
          end
          S_OVH: if (tcnt >= OVH_LAST) begin
            tcnt <= '0;
            st   <= blk_q ? S_PAD : S_RD;
          end
          S_RD: if (step_ack) begin
            data_q <= rev_q ? b_rdata : a_rdata;
            st     <= S_WR;
          end
          S_WR: if (step_ack) st <= S_PAD;
          S_PAD: if (slot_end) begin
            addr_q <= addr_nxt;
            cnt_q  <= cnt_q - 1'b1;
            pos_q  <= pos_q + 1'b1;
            tcnt   <= '0;
            if (cnt_q == {{(AW-1){1'b0}}, 1'b1}) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              st <= blk_q ? S_PAD : S_RD;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R11
  abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && line_hit) |=> (!busy && done && aborted));

  // R11
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && line_hit) |=> ($stable(cur_addr) && $stable(cur_count)));

  // R10
  blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && blk_q) |-> !(a_req || b_req));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && cur_count != $past(cur_count)) |-> cur_count == $past(cur_count) - 1'b1);

  // R1
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(bank_q) && $stable(port_q) && $stable(mode_q)));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $onehot0({a_req, b_req})) ##1 !done);

  // R9
  one_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_req, b_req}));
endmodule

// File: tb/dma_byte_engine_bench.sv
`timescale 1ns/1ps
module dma_byte_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0, cfg_b_to_a = 1'b0, line_hit = 1'b0;
  logic [2:0]  cfg_mode = '0;
  logic [1:0]  cfg_step = '0;
  logic [7:0]  cfg_port = '0, cfg_bank = '0;
  logic [15:0] cfg_count = '0, cfg_addr = '0;
  logic        busy, done, aborted, a_req, a_we, b_req, b_we, a_ack, b_ack;
  logic [15:0] cur_addr, cur_count;
  logic [23:0] a_addr;
  logic [7:0]  a_wdata, a_rdata, b_addr, b_wdata, b_rdata;

  int total = 0;
  int bad = 0;

  function automatic logic [7:0] fa(input logic [23:0] ad);
    return ad[7:0] ^ ad[15:8] ^ ad[23:16] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] fb(input logic [7:0] p);
    return p ^ 8'hA5;
  endfunction
  function automatic int exp_off(input int md, input int i);
    case (md)
      1, 5:    return i % 2;
      3, 7:    return (i / 2) % 2;
      4:       return i % 4;
      default: return 0;
    endcase
  endfunction
  function automatic string mode_tag(input int md);
    case (md)
      1, 5:    return "R6";
      3, 7:    return "R7";
      4:       return "R8";
      default: return "R5";
    endcase
  endfunction

  assign a_ack   = a_req;
  assign b_ack   = b_req;
  assign a_rdata = fa(a_addr);
  assign b_rdata = fb(b_addr);

  logic [23:0] ar_addr [0:255];
  logic [23:0] aw_addr [0:255];
  logic [7:0]  aw_data [0:255];
  logic [7:0]  bw_addr [0:255];
  logic [7:0]  bw_data [0:255];
  int ar_n = 0, aw_n = 0, bw_n = 0, br_n = 0;

  always @(posedge clk) begin
    if (a_req && a_ack && !a_we) begin ar_addr[ar_n & 255] <= a_addr; ar_n <= ar_n + 1; end
    if (a_req && a_ack && a_we)  begin aw_addr[aw_n & 255] <= a_addr; aw_data[aw_n & 255] <= a_wdata; aw_n <= aw_n + 1; end
    if (b_req && b_ack && b_we)  begin bw_addr[bw_n & 255] <= b_addr; bw_data[bw_n & 255] <= b_wdata; bw_n <= bw_n + 1; end
    if (b_req && b_ack && !b_we) br_n <= br_n + 1;
  end

  dma_byte_engine u_dma_byte_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_b_to_a(cfg_b_to_a), .cfg_mode(cfg_mode),
    .cfg_step(cfg_step), .cfg_port(cfg_port), .cfg_count(cfg_count), .cfg_bank(cfg_bank),
    .cfg_addr(cfg_addr), .line_hit(line_hit), .busy(busy), .done(done), .aborted(aborted),
    .cur_addr(cur_addr), .cur_count(cur_count), .a_req(a_req), .a_we(a_we), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_ack(a_ack), .b_req(b_req), .b_we(b_we),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_ack(b_ack)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic rev, input int md, input logic [1:0] stp, input logic [7:0] port,
                         input logic [15:0] n, input logic [7:0] bk, input logic [15:0] ad);
    cfg_b_to_a = rev; cfg_mode = 3'(md); cfg_step = stp; cfg_port = port;
    cfg_count = n; cfg_bank = bk; cfg_addr = ad;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    if (!done) chk("watchdog", 0, 1);
  endtask

  task automatic run_xfer(input logic rev, input int md, input logic [1:0] stp, input logic [7:0] port,
                          input logic [15:0] n, input logic [7:0] bk, input logic [15:0] ad, output int cyc);
    set_cfg(rev, md, stp, port, n, bk, ad);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
  endtask

  task automatic t_reset();
    chk("R12 busy", busy, 0);
    chk("R12 done", done, 0);
    chk("R12 aborted", aborted, 0);
    chk("R12 req", {a_req, b_req}, 0);
    chk("R12 count", cur_count, 0);
  endtask

  task automatic t_mode(input int md, input int n);
    int cyc, b0, a0;
    b0 = bw_n; a0 = ar_n;
    run_xfer(1'b0, md, 2'b00, 8'h18, 16'(n), 8'h02, 16'h0100, cyc);
    chk("R2 cycles", cyc, 8 + 8 * n);
    chk("R2 aborted", aborted, 0);
    chk("R2 final count", cur_count, 0);
    chk("R4 final addr", cur_addr, 16'h0100 + n);
    chk({mode_tag(md), " writes"}, bw_n - b0, n);
    chk("R4 reads", ar_n - a0, n);
    for (int i = 0; i < n; i++) begin
      chk({mode_tag(md), " port"}, bw_addr[(b0 + i) & 255], 8'h18 + exp_off(md, i));
      chk({mode_tag(md), " data"}, bw_data[(b0 + i) & 255], fa({8'h02, 16'h0100 + 16'(i)}));
    end
    if (md == 1 && (n % 2) == 1) chk("R6 odd end", bw_addr[(b0 + n - 1) & 255], 8'h18);
    @(negedge clk);
  endtask

  task automatic t_step();
    int cyc, a0;
    a0 = ar_n;
    run_xfer(1'b0, 0, 2'b00, 8'h22, 16'd4, 8'h05, 16'hFFFE, cyc);
    chk("R4 inc wrap addr", cur_addr, 16'h0002);
    for (int i = 0; i < 4; i++) chk("R4 inc wrap read", ar_addr[(a0 + i) & 255], {8'h05, 16'hFFFE + 16'(i)});
    @(negedge clk);
    a0 = ar_n;
    run_xfer(1'b0, 0, 2'b01, 8'h22, 16'd3, 8'h05, 16'h0001, cyc);
    chk("R4 dec addr", cur_addr, 16'hFFFE);
    for (int i = 0; i < 3; i++) chk("R4 dec read", ar_addr[(a0 + i) & 255], {8'h05, 16'h0001 - 16'(i)});
    @(negedge clk);
    a0 = ar_n;
    run_xfer(1'b0, 0, 2'b10, 8'h22, 16'd3, 8'h05, 16'h4000, cyc);
    chk("R4 fixed addr", cur_addr, 16'h4000);
    for (int i = 0; i < 3; i++) chk("R4 fixed read", ar_addr[(a0 + i) & 255], 24'h054000);
    @(negedge clk);
  endtask

  task automatic t_reverse();
    int cyc, a0, b0, r0;
    a0 = aw_n; b0 = bw_n; r0 = br_n;
    run_xfer(1'b1, 4, 2'b01, 8'h30, 16'd5, 8'h01, 16'h2000, cyc);
    chk("R9 cycles", cyc, 48);
    chk("R9 b reads", br_n - r0, 5);
    chk("R9 no b writes", bw_n - b0, 0);
    chk("R9 a writes", aw_n - a0, 5);
    for (int i = 0; i < 5; i++) begin
      chk("R9 a addr", aw_addr[(a0 + i) & 255], {8'h01, 16'h2000 - 16'(i)});
      chk("R9 data", aw_data[(a0 + i) & 255], fb(8'h30 + 8'(exp_off(4, i))));
    end
    @(negedge clk);
  endtask

  task automatic t_blocked();
    int cyc, a0, b0, r0, w0;
    a0 = ar_n; b0 = bw_n;
    run_xfer(1'b0, 0, 2'b00, 8'h80, 16'd4, 8'h7E, 16'h0300, cyc);
    chk("R10 cycles", cyc, 40);
    chk("R10 no b writes", bw_n - b0, 0);
    chk("R10 no a reads", ar_n - a0, 0);
    chk("R10 addr", cur_addr, 16'h0304);
    chk("R10 count", cur_count, 0);
    @(negedge clk);
    r0 = br_n; w0 = aw_n;
    run_xfer(1'b1, 0, 2'b00, 8'h80, 16'd2, 8'h7F, 16'h0400, cyc);
    chk("R10 reverse b reads", br_n - r0, 2);
    chk("R10 reverse a writes", aw_n - w0, 2);
    @(negedge clk);
    b0 = bw_n;
    run_xfer(1'b0, 0, 2'b00, 8'h81, 16'd1, 8'h7F, 16'h0500, cyc);
    chk("R10 other port written", bw_n - b0, 1);
    @(negedge clk);
  endtask

  task automatic t_abort();
    set_cfg(1'b0, 0, 2'b00, 8'h18, 16'd10, 8'h03, 16'h1000);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (34) @(negedge clk);
    chk("R11 busy before", busy, 1);
    line_hit = 1'b1;
    @(negedge clk);
    line_hit = 1'b0;
    chk("R11 done", done, 1);
    chk("R11 aborted", aborted, 1);
    chk("R11 idle", busy, 0);
    chk("R11 count held", cur_count, 16'd7);
    chk("R11 addr held", cur_addr, 16'h1003);
    @(negedge clk);
    chk("R11 pulse", done, 0);
  endtask

  task automatic t_zero();
    set_cfg(1'b0, 0, 2'b00, 8'h18, 16'd0, 8'h03, 16'h0000);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (32) @(negedge clk);
    chk("R3 busy", busy, 1);
    chk("R3 count", cur_count, 16'hFFFD);
    line_hit = 1'b1;
    @(negedge clk);
    line_hit = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_busy_start();
    int cyc, b0;
    b0 = bw_n;
    set_cfg(1'b0, 0, 2'b00, 8'h10, 16'd2, 8'h04, 16'h0600);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    repeat (5) begin @(negedge clk); cyc++; end
    set_cfg(1'b1, 4, 2'b01, 8'h20, 16'd9, 8'h06, 16'h0700);
    start = 1'b1;
    @(negedge clk); cyc++;
    start = 1'b0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    chk("R1 cycles", cyc, 24);
    chk("R1 writes", bw_n - b0, 2);
    chk("R1 port", bw_addr[(b0 + 1) & 255], 8'h10);
    chk("R1 addr", cur_addr, 16'h0602);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 restart", busy, 1);
    line_hit = 1'b1;
    @(negedge clk);
    line_hit = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode(0, 3); t_mode(2, 3); t_mode(6, 2);
    t_mode(1, 5); t_mode(5, 4);
    t_mode(3, 6); t_mode(7, 5);
    t_mode(4, 6);
    t_step();
    t_reverse();
    t_blocked();
    t_abort();
    t_zero();
    t_busy_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule